// File: doc/BRIEF.md
# Byte-Buffered NRZ Sub-Audio Transmitter

This block turns bytes supplied by a host controller into a continuous non-return-to-zero bit stream at a programmable low baud rate, for signalling below the voice band. Each bit leaves as a signed level code: a sign for the data value and an unsigned step index that carries the selected output gain plus an optional boost. A downstream converter and smoothing filter turn that code into an analog level. An idle flag tells the downstream stage to hold the output at its bias point whenever nothing is being sent.

Bytes go through a one-byte holding register in front of the shift register. The first byte written while idle starts transmission at once. After that, a buffer-ready flag asks the host for the next byte each time a byte enters the shifter. If the host misses the refill deadline, the byte in flight completes, the stream stops, and a transmission-complete flag is raised. The host builds its own codewords; this block only serializes, paces and level-codes them.

Top module: `nrz_subaudio_tx`

## Requirements
- R1: After reset, idle_o = 1, buf_ready_o = 0, tx_done_o = 0, level_o = 0 and sign_o = 0.
- R2: Each bit lasts exactly 32 × Q clock cycles, with Q taken from baud_q_i at the start of the bit. Q = 0 is treated as Q = 1.
- R3: Bytes are sent MSB first and not inverted. A data 1 drives sign_o = 0 and a data 0 drives sign_o = 1.
- R4: A write while idle and enabled starts the MSB on the next clock edge. buf_ready_o rises on that same edge and tx_done_o is cleared.
- R5: While sending, a byte written into the holding register follows the current byte with no gap. buf_ready_o rises again on the edge where that byte moves into the shifter, so it rises once per 8 bits.
- R6: If the holding register is still empty 7 bit periods after a byte entered the shifter, that byte is the last one. Its final bit completes, then idle_o = 1 and tx_done_o = 1 on the same edge. A write made after that deadline is discarded.
- R7: A write while enabled clears both flags. A one-cycle general-reset pulse clears both flags without stopping transmission. enc_en_i = 0 stops transmission, empties the holding register, clears both flags and ignores writes.
- R8: A write while the holding register is already full replaces the held byte without any error indication.
- R9: While sending, level_o equals the 3-bit gain code (0 to 6, with code 7 treated as 6), plus any boost. While idle, level_o = 0 and sign_o = 0.
- R10: With pre_emph_i = 1 at the start of a bit, level_o is raised by 2 steps for that bit when the next bit to be sent differs from it. For the last bit of a byte, the next bit is the MSB of the held byte. The final bit before idle is never raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock (crystal rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_en_i | input | 1 | Encoder enable; low powers the encoder down |
| greset_i | input | 1 | General reset pulse, clears flags |
| wr_i | input | 1 | Host byte write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| baud_q_i | input | 11 | Baud divisor Q |
| gain_i | input | 3 | Output gain code, 0.86 dB per step |
| pre_emph_i | input | 1 | Enable pre-emphasis boost |
| buf_ready_o | output | 1 | Holding register wants a byte |
| tx_done_o | output | 1 | Transmission ended on underrun |
| idle_o | output | 1 | Output parked at bias |
| sign_o | output | 1 | 1 = negative level (data 0) |
| level_o | output | 4 | Unsigned level step index |

## Verification
The assertions assume greset_i and wr_i are single-cycle strobes from a synchronous host, that enc_en_i is stable around writes, and that baud_q_i changes only while the encoder is idle. The stimulus drives every strobe for exactly one cycle at a falling edge and changes baud_q_i only after idle_o has returned high. It never makes a write coincide with a byte boundary, so ready and complete flag timing is tested at unambiguous edges. The expected level and sign for every bit are derived from the byte values, gain code and look-ahead rule in the requirements.

// File: rtl/nrz_tx_pkg.sv
package nrz_tx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // gain code saturation: top code is unused and maps to the highest valid step
  function automatic int unsigned clamp_gain(input int unsigned code, input int unsigned max_code);
    return (code > max_code) ? max_code : code;
  endfunction
endpackage

// File: rtl/nrz_baud_gen.sv
module nrz_baud_gen #(
  parameter int Q_W      = 11,
  parameter int PRESCALE = 32,
  localparam int CNT_W   = Q_W + $clog2(PRESCALE) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [Q_W-1:0] q_i,
  output logic           tick_o
);
  logic [Q_W-1:0]   q_eff;
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] cnt_q;

  assign q_eff     = (q_i == '0) ? Q_W'(1) : q_i;
  assign period_m1 = CNT_W'(q_eff) * CNT_W'(PRESCALE) - CNT_W'(1);
  assign tick_o    = run_i && (cnt_q == '0);

  // held at full period while idle so the first bit is full length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= period_m1;
    else                       cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/nrz_tx_seq.sv
module nrz_tx_seq
  import nrz_tx_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int LAST  = BYTE_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              greset_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              tick_i,
  input  logic              pre_emph_i,
  output logic              sending_o,
  output logic              cur_bit_o,
  output logic              emph_o,
  output logic              buf_ready_o,
  output logic              tx_done_o
);
  tx_state_e         state_q, state_d;
  logic [BYTE_W-1:0] sh_q, sh_d, hold_q, hold_d;
  logic [BIT_W-1:0]  idx_q, idx_d;
  logic              hold_full_q, hold_full_d;
  logic              final_q, final_d;
  logic              emph_q, emph_d;
  logic              ready_q, ready_d;
  logic              done_q, done_d;
  logic              wr_ok, ready_set, done_set, nxt_full, nxt_bit;

  assign wr_ok = wr_i & en_i;

  always_comb begin
    state_d     = state_q;
    sh_d        = sh_q;
    hold_d      = hold_q;
    idx_d       = idx_q;
    hold_full_d = hold_full_q;
    final_d     = final_q;
    emph_d      = emph_q;
    ready_set   = 1'b0;
    done_set    = 1'b0;
    nxt_full    = 1'b0;
    nxt_bit     = 1'b0;
    if (!en_i) begin
      state_d     = ST_IDLE;
      hold_full_d = 1'b0;
      final_d     = 1'b0;
      emph_d      = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_ok) begin
            sh_d      = wr_data_i;
            idx_d     = '0;
            state_d   = ST_SEND;
            final_d   = 1'b0;
            emph_d    = pre_emph_i & (wr_data_i[LAST] ^ wr_data_i[LAST-1]);
            ready_set = 1'b1;
          end
        end
        ST_SEND: begin
          // writes after a missed deadline are dropped
          if (wr_ok && !final_q) begin
            hold_d      = wr_data_i;
            hold_full_d = 1'b1;
          end
          if (tick_i) begin
            if (idx_q == BIT_W'(LAST)) begin
              if (final_q) begin
                state_d     = ST_IDLE;
                hold_full_d = 1'b0;
                emph_d      = 1'b0;
                done_set    = 1'b1;
              end else begin
                sh_d        = hold_q;
                idx_d       = '0;
                hold_full_d = wr_ok;
                emph_d      = pre_emph_i & (hold_q[LAST] ^ hold_q[LAST-1]);
                ready_set   = !wr_ok;
              end
            end else begin
              sh_d  = sh_q << 1;
              idx_d = idx_q + BIT_W'(1);
              if (idx_q == BIT_W'(LAST - 1)) begin
                // refill deadline: look ahead into the holding register
                nxt_full = hold_full_q | wr_ok;
                nxt_bit  = wr_ok ? wr_data_i[LAST] : hold_q[LAST];
                final_d  = !nxt_full;
                emph_d   = pre_emph_i & nxt_full & (sh_q[LAST-1] ^ nxt_bit);
              end else begin
                emph_d   = pre_emph_i & (sh_q[LAST-1] ^ sh_q[LAST-2]);
              end
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!en_i || greset_i) begin
      ready_d = 1'b0;
      done_d  = 1'b0;
    end else begin
      ready_d = ready_set ? 1'b1 : (wr_ok ? 1'b0 : ready_q);
      done_d  = done_set  ? 1'b1 : (wr_ok ? 1'b0 : done_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      hold_q      <= '0;
      idx_q       <= '0;
      hold_full_q <= 1'b0;
      final_q     <= 1'b0;
      emph_q      <= 1'b0;
      ready_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      sh_q        <= sh_d;
      hold_q      <= hold_d;
      idx_q       <= idx_d;
      hold_full_q <= hold_full_d;
      final_q     <= final_d;
      emph_q      <= emph_d;
      ready_q     <= ready_d;
      done_q      <= done_d;
    end
  end

  assign sending_o   = (state_q == ST_SEND);
  assign cur_bit_o   = sh_q[LAST];
  assign emph_o      = emph_q;
  assign buf_ready_o = ready_q;
  assign tx_done_o   = done_q;
endmodule

// File: rtl/nrz_level_map.sv
module nrz_level_map
  import nrz_tx_pkg::*;
#(
  parameter int GAIN_W     = 3,
  parameter int LVL_W      = 4,
  parameter int EMPH_STEPS = 2,
  localparam int GAIN_MAX  = (1 << GAIN_W) - 2
) (
  input  logic              sending_i,
  input  logic              cur_bit_i,
  input  logic              emph_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              idle_o,
  output logic              sign_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [LVL_W-1:0] base_lvl;

  assign base_lvl = LVL_W'(clamp_gain(int'(gain_i), GAIN_MAX));
  assign idle_o   = !sending_i;
  assign sign_o   = sending_i & !cur_bit_i;
  assign level_o  = !sending_i ? '0 :
                    (base_lvl + (emph_i ? LVL_W'(EMPH_STEPS) : '0));
endmodule

// File: rtl/nrz_subaudio_tx.sv
module nrz_subaudio_tx #(
  parameter int BYTE_W     = 8,
  parameter int Q_W        = 11,
  parameter int PRESCALE   = 32,
  parameter int GAIN_W     = 3,
  parameter int EMPH_STEPS = 2,
  parameter int LVL_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_en_i,
  input  logic              greset_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [Q_W-1:0]    baud_q_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic              pre_emph_i,
  output logic              buf_ready_o,
  output logic              tx_done_o,
  output logic              idle_o,
  output logic              sign_o,
  output logic [LVL_W-1:0]  level_o
);
  logic sending, tick, cur_bit, emph;

  nrz_baud_gen #(.Q_W(Q_W), .PRESCALE(PRESCALE)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sending),
    .q_i    (baud_q_i),
    .tick_o (tick)
  );

  nrz_tx_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (enc_en_i),
    .greset_i    (greset_i),
    .wr_i        (wr_i),
    .wr_data_i   (wr_data_i),
    .tick_i      (tick),
    .pre_emph_i  (pre_emph_i),
    .sending_o   (sending),
    .cur_bit_o   (cur_bit),
    .emph_o      (emph),
    .buf_ready_o (buf_ready_o),
    .tx_done_o   (tx_done_o)
  );

  nrz_level_map #(.GAIN_W(GAIN_W), .LVL_W(LVL_W), .EMPH_STEPS(EMPH_STEPS)) u_lvl (
    .sending_i (sending),
    .cur_bit_i (cur_bit),
    .emph_i    (emph),
    .gain_i    (gain_i),
    .idle_o    (idle_o),
    .sign_o    (sign_o),
    .level_o   (level_o)
  );
endmodule

// File: rtl/nrz_subaudio_tx_chk.sv
module nrz_subaudio_tx_chk #(
  parameter int GAIN_W     = 3,
  parameter int EMPH_STEPS = 2,
  parameter int LVL_W      = 4,
  localparam int LVL_MAX   = (1 << GAIN_W) - 2 + EMPH_STEPS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enc_en_i,
  input logic             greset_i,
  input logic             buf_ready_o,
  input logic             tx_done_o,
  input logic             idle_o,
  input logic             sign_o,
  input logic [LVL_W-1:0] level_o
);
  // R9
  idle_at_bias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (level_o == '0 && !sign_o));

  // R10
  level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= LVL_MAX);

  // R6
  done_implies_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> idle_o);

  // R7
  powerdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_en_i |=> (idle_o && !buf_ready_o && !tx_done_o));

  // R7
  greset_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    greset_i |=> (!buf_ready_o && !tx_done_o));

  // R4
  start_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(idle_o) && !$past(greset_i)) |-> buf_ready_o);
endmodule

bind nrz_subaudio_tx nrz_subaudio_tx_chk #(
  .GAIN_W(GAIN_W), .EMPH_STEPS(EMPH_STEPS), .LVL_W(LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enc_en_i    (enc_en_i),
  .greset_i    (greset_i),
  .buf_ready_o (buf_ready_o),
  .tx_done_o   (tx_done_o),
  .idle_o      (idle_o),
  .sign_o      (sign_o),
  .level_o     (level_o)
);

// File: tb/nrz_subaudio_tx_test.sv
module nrz_subaudio_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        greset = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [10:0] q = 11'd1;
  logic [2:0]  gain = 3'd3;
  logic        pre = 1'b0;
  logic        buf_ready, tx_done, idle, sign;
  logic [3:0]  level;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nrz_subaudio_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .enc_en_i(en), .greset_i(greset),
    .wr_i(wr), .wr_data_i(wdata), .baud_q_i(q), .gain_i(gain),
    .pre_emph_i(pre), .buf_ready_o(buf_ready), .tx_done_o(tx_done),
    .idle_o(idle), .sign_o(sign), .level_o(level)
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_gain();
    return (gain == 3'd7) ? 6 : int'(gain);
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // call at a falling edge; returns one cycle later
  task automatic wr_byte(input logic [7:0] b);
    wr = 1'b1;
    wdata = b;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // called half a cycle after the edge that starts byte b; ends mid last bit
  task automatic tx_bits(input logic [7:0] b, input int p, input bit nxt_en,
                         input logic [7:0] nb, input string req);
    bit boost;
    wait_cyc(p/2);
    for (int k = 0; k < 8; k++) begin
      if (k < 7) boost = pre && (b[7-k] != b[6-k]);
      else       boost = pre && nxt_en && (b[0] != nb[7]);
      chk_eq(req, "sign", int'(sign), int'(!b[7-k]));
      chk_eq(req, "level", int'(level), eff_gain() + (boost ? 2 : 0));
      chk_eq(req, "idle", int'(idle), 0);
      if (k < 7) begin
        if (k == 3 && nxt_en) begin
          wr_byte(nb);
          chk_eq("R5", "ready after refill", int'(buf_ready), 0);
          wait_cyc(p - 1);
        end else begin
          wait_cyc(p);
        end
      end
    end
  endtask

  task automatic t_reset();
    chk_eq("R1", "idle", int'(idle), 1);
    chk_eq("R1", "ready", int'(buf_ready), 0);
    chk_eq("R1", "done", int'(tx_done), 0);
    chk_eq("R1", "level", int'(level), 0);
    chk_eq("R1", "sign", int'(sign), 0);
  endtask

  task automatic t_single();
    q = 11'd1; gain = 3'd3; pre = 1'b0;
    wr_byte(8'hA5);
    chk_eq("R4", "ready at start", int'(buf_ready), 1);
    chk_eq("R4", "started", int'(idle), 0);
    chk_eq("R4", "done cleared", int'(tx_done), 0);
    tx_bits(8'hA5, 32, 1'b0, 8'h00, "R3,R9");
    wait_cyc(16);
    chk_eq("R6", "idle after underrun", int'(idle), 1);
    chk_eq("R6", "done after underrun", int'(tx_done), 1);
    chk_eq("R9", "idle level", int'(level), 0);
  endtask

  task automatic t_stream();
    q = 11'd1; gain = 3'd4; pre = 1'b0;
    wr_byte(8'h3C);
    chk_eq("R7", "write clears done", int'(tx_done), 0);
    tx_bits(8'h3C, 32, 1'b1, 8'hC3, "R5");
    wait_cyc(16);
    chk_eq("R5", "ready on reload", int'(buf_ready), 1);
    chk_eq("R5", "no gap", int'(idle), 0);
    tx_bits(8'hC3, 32, 1'b0, 8'h00, "R5,R3");
    wait_cyc(16);
    chk_eq("R6", "stream end", int'(tx_done), 1);
  endtask

  task automatic t_emph();
    q = 11'd1; gain = 3'd2; pre = 1'b1;
    wr_byte(8'h96);
    tx_bits(8'h96, 32, 1'b1, 8'hE9, "R10");
    wait_cyc(16);
    tx_bits(8'hE9, 32, 1'b0, 8'h00, "R10");
    wait_cyc(16);
    chk_eq("R10", "idle after emph", int'(idle), 1);
    pre = 1'b0;
  endtask

  task automatic t_gain();
    q = 11'd1; gain = 3'd7; pre = 1'b0;
    wr_byte(8'hFF);
    wait_cyc(16);
    chk_eq("R9", "code 7 clamps", int'(level), 6);
    gain = 3'd0;
    wait_cyc(1);
    chk_eq("R9", "code 0", int'(level), 0);
    chk_eq("R9", "still sending", int'(idle), 0);
    wait_cyc(8*32);
    chk_eq("R9", "back to bias", int'(idle), 1);
    gain = 3'd3;
  endtask

  task automatic t_baud();
    q = 11'd3;
    wr_byte(8'hF0);
    wait_cyc(4*96 - 1);
    chk_eq("R2", "Q=3 before edge", int'(sign), 0);
    wait_cyc(1);
    chk_eq("R2", "Q=3 after edge", int'(sign), 1);
    wait_cyc(4*96 + 8);
    chk_eq("R2", "Q=3 ended", int'(idle), 1);
    q = 11'd0;
    wr_byte(8'hF0);
    wait_cyc(4*32 - 1);
    chk_eq("R2", "Q=0 before edge", int'(sign), 0);
    wait_cyc(1);
    chk_eq("R2", "Q=0 after edge", int'(sign), 1);
    wait_cyc(4*32 + 8);
    chk_eq("R2", "Q=0 ended", int'(idle), 1);
    q = 11'd1;
  endtask

  task automatic t_late();
    q = 11'd1;
    wr_byte(8'h55);
    wait_cyc(7*32 + 16);
    chk_eq("R6", "last bit running", int'(idle), 0);
    wr_byte(8'hAA);
    wait_cyc(15);
    chk_eq("R6", "late end idle", int'(idle), 1);
    chk_eq("R6", "late end done", int'(tx_done), 1);
    wait_cyc(64);
    chk_eq("R6", "late byte dropped", int'(idle), 1);
  endtask

  task automatic t_overwrite();
    q = 11'd1; gain = 3'd5; pre = 1'b0;
    wr_byte(8'h00);
    wait_cyc(2*32);
    wr_byte(8'hFF);
    wait_cyc(31);
    wr_byte(8'h5A);
    chk_eq("R8", "no error flag", int'(tx_done), 0);
    wait_cyc(5*32 - 1);
    chk_eq("R8", "replacement loaded", int'(buf_ready), 1);
    tx_bits(8'h5A, 32, 1'b0, 8'h00, "R8");
    wait_cyc(16);
    chk_eq("R8", "end", int'(idle), 1);
  endtask

  task automatic t_clear();
    q = 11'd1;
    chk_eq("R7", "done before greset", int'(tx_done), 1);
    greset = 1'b1; wait_cyc(1); greset = 1'b0;
    chk_eq("R7", "greset clears done", int'(tx_done), 0);
    wr_byte(8'h81);
    chk_eq("R7", "ready set", int'(buf_ready), 1);
    wait_cyc(10);
    greset = 1'b1; wait_cyc(1); greset = 1'b0;
    chk_eq("R7", "greset clears ready", int'(buf_ready), 0);
    chk_eq("R7", "greset keeps sending", int'(idle), 0);
    en = 1'b0; wait_cyc(1);
    chk_eq("R7", "powerdown idles", int'(idle), 1);
    chk_eq("R7", "powerdown ready", int'(buf_ready), 0);
    wr_byte(8'h11);
    chk_eq("R7", "write ignored while off", int'(idle), 1);
    en = 1'b1; wait_cyc(40);
    chk_eq("R7", "nothing pending", int'(idle), 1);
    chk_eq("R7", "no flags", int'(buf_ready) + int'(tx_done), 0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_single();
    t_stream();
    t_emph();
    t_gain();
    t_baud();
    t_late();
    t_overwrite();
    t_clear();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule